// File: doc/BRIEF.md
# Peripheral Request Router and Channel Arbiter

This block sits between a set of peripheral DMA request lines and a bank of physical DMA channels. Each request line has a small routing register. The register says whether the line is routed and which channel it drives. Every routed, asserted line raises the request of its target channel. Channels that are both running and requesting then compete for the shared transfer bus. The block issues one-hot grants by fixed priority levels. Within a level the grant rotates among the requesters.

The routing registers live in two address banks. Lines below 64 use the lower bank and the remaining lines use the upper bank. One more read-only word reports which channels have an interrupt pending. Software sets up routes through the register port. The channel engines consume `ch_req_o` and `grant_o` and report the end of each burst on `ch_done_i`.

Top module: `dma_req_router`

## Requirements
- R1: After reset no grant is issued, no channel request is raised, and every routing register reads zero.
- R2: A routing register keeps only bit 7 (route enable) and bits 4:0 (target channel). All other bits read back as zero.
- R3: The routing register of line l sits at 0x100 + 4*l for l < 64 and at 0x1100 + 4*(l-64) for l >= 64. The two banks do not alias.
- R4: A line raises its target channel's request only while its route enable is set. Writing zero to its register removes the route.
- R5: When several routed lines target the same channel, the channel request is the OR of those lines.
- R6: A channel can be granted only while its run input is high and it has a request.
- R7: A channel's priority level is bits 3:2 of its index, and level 0 is the highest. The lowest-numbered level that has an eligible channel wins.
- R8: Within one level, successive grants rotate round-robin, starting after the last channel granted in that level. Out of reset the search starts at channel 0.
- R9: A grant appears the cycle after eligibility is seen. It holds until the granted channel pulses `ch_done_i`, which clears it on the next edge. A new grant can appear one cycle after that.
- R10: The word at offset 0x000 reads bit n as channel n's interrupt input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 13 | Register byte address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from the address |
| periph_req_i | input | NUM_REQ | Peripheral request lines |
| ch_run_i | input | NUM_CH | Channel running flags |
| ch_irq_i | input | NUM_CH | Channel interrupt pending flags |
| ch_done_i | input | NUM_CH | Burst completion pulses |
| ch_req_o | output | NUM_CH | Forwarded per-channel requests |
| grant_o | output | NUM_CH | One-hot bus grant |

## Verification
A corrupted routing entry shows up at `ch_req_o` right after the write edge. It can also be read back at once through the register port. A wrong round-robin pointer or level decode does not show on the current grant. It appears only at the next arbitration, one cycle after a burst completes. The bench therefore walks several grant rotations. A grant that is lost or held too long shows at the first edge after a `ch_done_i` pulse.

// File: rtl/dma_req_router_pkg.sv
package dma_req_router_pkg;
  localparam int ADDR_W      = 13;
  localparam int DATA_W      = 32;
  localparam int MAP_VLD_BIT = 7;
  localparam int MAP_CH_W    = 5;
  localparam int BANK_LINES  = 64;
  localparam int NUM_LVL     = 4;
  localparam logic [ADDR_W-1:0] BANK0_BASE  = 13'h0100;
  localparam logic [ADDR_W-1:0] BANK1_BASE  = 13'h1100;
  localparam logic [ADDR_W-1:0] SUMMARY_OFS = 13'h0000;

  function automatic int prio_level(int ch);
    return (ch >> 2) & 3;
  endfunction

  function automatic logic [ADDR_W-1:0] line_addr(int line);
    logic [ADDR_W-1:0] base;
    base = (line < BANK_LINES) ? BANK0_BASE : BANK1_BASE;
    return base + ADDR_W'((line % BANK_LINES) * 4);
  endfunction
endpackage

// File: rtl/reqmap_regs.sv
module reqmap_regs
  import dma_req_router_pkg::*;
#(
  parameter int NUM_REQ = 80,
  parameter int NUM_CH  = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   rdata_o,
  input  logic [NUM_REQ-1:0]  req_i,
  output logic [NUM_CH-1:0]   ch_req_o
);
  logic [NUM_REQ-1:0]               vld_q;
  logic [NUM_REQ-1:0][MAP_CH_W-1:0] ch_q;
  logic [NUM_REQ-1:0]               sel;
  logic [NUM_REQ-1:0]               live;

  for (genvar l = 0; l < NUM_REQ; l++) begin : g_line
    assign sel[l]  = (addr_i == line_addr(l));
    assign live[l] = vld_q[l] & req_i[l];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[l] <= 1'b0;
        ch_q[l]  <= '0;
      end else if (we_i && sel[l]) begin
        vld_q[l] <= wdata_i[MAP_VLD_BIT];
        ch_q[l]  <= wdata_i[MAP_CH_W-1:0];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int l = 0; l < NUM_REQ; l++) begin
      if (sel[l]) begin
        rdata_o[MAP_VLD_BIT]    = vld_q[l];
        rdata_o[MAP_CH_W-1:0]   = ch_q[l];
      end
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_fwd
    always_comb begin
      ch_req_o[c] = 1'b0;
      for (int l = 0; l < NUM_REQ; l++) begin
        if (live[l] && (ch_q[l] == MAP_CH_W'(c))) ch_req_o[c] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/reqmap_arbiter.sv
module reqmap_arbiter
  import dma_req_router_pkg::*;
#(
  parameter int NUM_CH = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] elig_i,
  input  logic [NUM_CH-1:0] done_i,
  output logic [NUM_CH-1:0] grant_o
);
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic [NUM_CH-1:0]                grant_q;
  logic [NUM_LVL-1:0][CH_W-1:0]     last_q;
  logic [NUM_LVL-1:0]               lvl_any;
  logic [NUM_LVL-1:0][CH_W-1:0]     lvl_pick;
  logic [1:0]                       win_lvl;
  logic                             win_any;

  for (genvar lv = 0; lv < NUM_LVL; lv++) begin : g_lvl
    logic            any;
    logic [CH_W-1:0] pick;
    always_comb begin
      any  = 1'b0;
      pick = '0;
      for (int k = 1; k <= NUM_CH; k++) begin
        int idx;
        idx = (int'(last_q[lv]) + k) % NUM_CH;
        if (!any && elig_i[idx] && prio_level(idx) == lv) begin
          any  = 1'b1;
          pick = CH_W'(idx);
        end
      end
    end
    assign lvl_any[lv]  = any;
    assign lvl_pick[lv] = pick;
  end

  // lowest level number wins
  always_comb begin
    win_any = 1'b0;
    win_lvl = '0;
    for (int lv = NUM_LVL - 1; lv >= 0; lv--) begin
      if (lvl_any[lv]) begin
        win_any = 1'b1;
        win_lvl = 2'(lv);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grant_q <= '0;
      for (int lv = 0; lv < NUM_LVL; lv++) last_q[lv] <= CH_W'(NUM_CH - 1);
    end else if (|grant_q) begin
      if (|(grant_q & done_i)) grant_q <= '0;
    end else if (win_any) begin
      grant_q                      <= '0;
      grant_q[lvl_pick[win_lvl]]   <= 1'b1;
      last_q[win_lvl]              <= lvl_pick[win_lvl];
    end
  end

  assign grant_o = grant_q;
endmodule

// File: rtl/dma_req_router.sv
module dma_req_router
  import dma_req_router_pkg::*;
#(
  parameter int NUM_REQ = 80,
  parameter int NUM_CH  = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_we_i,
  input  logic [12:0]        reg_addr_i,
  input  logic [31:0]        reg_wdata_i,
  output logic [31:0]        reg_rdata_o,
  input  logic [NUM_REQ-1:0] periph_req_i,
  input  logic [NUM_CH-1:0]  ch_run_i,
  input  logic [NUM_CH-1:0]  ch_irq_i,
  input  logic [NUM_CH-1:0]  ch_done_i,
  output logic [NUM_CH-1:0]  ch_req_o,
  output logic [NUM_CH-1:0]  grant_o
);
  logic [DATA_W-1:0] map_rdata;
  logic [DATA_W-1:0] sum_rdata;

  reqmap_regs #(.NUM_REQ(NUM_REQ), .NUM_CH(NUM_CH)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (reg_we_i),
    .addr_i   (reg_addr_i),
    .wdata_i  (reg_wdata_i),
    .rdata_o  (map_rdata),
    .req_i    (periph_req_i),
    .ch_req_o (ch_req_o)
  );

  reqmap_arbiter #(.NUM_CH(NUM_CH)) u_arb (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .elig_i  (ch_req_o & ch_run_i),
    .done_i  (ch_done_i),
    .grant_o (grant_o)
  );

  always_comb begin
    sum_rdata = '0;
    sum_rdata[NUM_CH-1:0] = ch_irq_i;
  end

  assign reg_rdata_o = (reg_addr_i == SUMMARY_OFS) ? sum_rdata : map_rdata;
endmodule

// File: rtl/dma_req_router_chk.sv
module dma_req_router_chk #(
  parameter int NUM_REQ = 80,
  parameter int NUM_CH  = 32
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_REQ-1:0] periph_req_i,
  input logic [NUM_CH-1:0]  ch_run_i,
  input logic [NUM_CH-1:0]  ch_done_i,
  input logic [NUM_CH-1:0]  ch_req_o,
  input logic [NUM_CH-1:0]  grant_o
);
  p_grant_onehot_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o));

  p_grant_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o != '0 && (grant_o & ch_done_i) == '0) |=> grant_o == $past(grant_o));

  p_release_gap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((grant_o & ch_done_i) != '0) |=> grant_o == '0);

  p_grant_eligible_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o == '0) |=> (grant_o == '0 || ($past(ch_req_o & ch_run_i) & grant_o) != '0));

  p_fwd_needs_line_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ch_req_o != '0) |-> (periph_req_i != '0));
endmodule

bind dma_req_router dma_req_router_chk #(.NUM_REQ(NUM_REQ), .NUM_CH(NUM_CH)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .periph_req_i (periph_req_i),
  .ch_run_i     (ch_run_i),
  .ch_done_i    (ch_done_i),
  .ch_req_o     (ch_req_o),
  .grant_o      (grant_o)
);

// File: tb/dma_req_router_test.sv
`timescale 1ns/1ps
module dma_req_router_test;
  localparam int NUM_REQ = 80;
  localparam int NUM_CH  = 32;
  localparam int NV      = 6;

  // table: write address, write data, request line to raise, expected ch_req_o
  localparam logic [12:0] T_ADDR [NV] = '{13'h10C, 13'h1118, 13'h118, 13'h10C, 13'h1100, 13'h100};
  localparam logic [31:0] T_DATA [NV] = '{32'h85, 32'h91, 32'h11, 32'h0, 32'h9F, 32'h80};
  localparam int          T_LINE [NV] = '{3, 70, 6, 3, 64, 0};
  localparam logic [31:0] T_EXP  [NV] = '{32'h20, 32'h0002_0000, 32'h0, 32'h0, 32'h8000_0000, 32'h1};

  logic clk = 0;
  logic rst_ni = 0;
  logic reg_we = 0;
  logic [12:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [NUM_REQ-1:0] preq = '0;
  logic [NUM_CH-1:0] run = '0, irq = '0, done = '0;
  logic [NUM_CH-1:0] ch_req, grant;
  int errors = 0, checks = 0;

  always #2 clk = ~clk;

  dma_req_router #(.NUM_REQ(NUM_REQ), .NUM_CH(NUM_CH)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .periph_req_i(preq),
    .ch_run_i(run), .ch_irq_i(irq), .ch_done_i(done), .ch_req_o(ch_req), .grant_o(grant)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(logic [12:0] a, logic [31:0] d);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    tick();
    reg_we = 0;
  endtask

  task automatic rd(logic [12:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic finish_burst(int c, string tag);
    done[c] = 1'b1;
    tick();
    done = '0;
    chk(tag, grant, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    #10;
    chk("R1 grant at reset", grant, 32'h0);
    chk("R1 ch_req at reset", ch_req, 32'h0);
    rd(13'h104, d);
    chk("R1 map reg at reset", d, 32'h0);
    @(negedge clk);
    rst_ni = 1;
    tick();

    // table walk: R2 R3 R4
    for (int i = 0; i < NV; i++) begin
      wr(T_ADDR[i], T_DATA[i]);
      preq = '0;
      preq[T_LINE[i]] = 1'b1;
      #1 chk($sformatf("R3/R4 vector %0d", i), ch_req, T_EXP[i]);
      @(negedge clk);
    end
    preq = '0;

    rd(13'h1118, d);
    chk("R3 upper bank readback", d, 32'h91);
    rd(13'h118, d);
    chk("R3 lower bank no alias", d, 32'h11);
    wr(13'h104, 32'hFFFF_FFFF);
    rd(13'h104, d);
    chk("R2 field mask", d, 32'h9F);

    irq = 32'hA500_0001;
    rd(13'h000, d);
    chk("R10 summary", d, 32'hA500_0001);

    // R5: lines 9 and 10 both to channel 7
    wr(13'h124, 32'h87);
    wr(13'h128, 32'h87);
    preq = '0; preq[9] = 1'b1;
    #1 chk("R5 line 9 to ch7", ch_req, 32'h80);
    preq = '0; preq[10] = 1'b1;
    #1 chk("R5 line 10 to ch7", ch_req, 32'h80);
    preq = '0;
    @(negedge clk);

    // identity map lines 0..31
    for (int l = 0; l < 32; l++) wr(13'h100 + 13'(l * 4), 32'h80 | l);
    run = '1;

    // R7: ch18 (lvl0) beats ch5 (lvl1) and ch13 (lvl3)
    preq[5] = 1; preq[18] = 1; preq[13] = 1;
    tick();
    chk("R7 level 0 wins", grant, 32'h0004_0000);
    preq[2] = 1;
    tick();
    chk("R9 hold against new req", grant, 32'h0004_0000);
    done[5] = 1;
    tick();
    done = '0;
    chk("R9 foreign done ignored", grant, 32'h0004_0000);
    preq = '0;
    finish_burst(18, "R9 release after done");
    tick();
    chk("R9 no requesters no grant", grant, 32'h0);

    // R8 round robin in level 0 (last granted 18)
    preq[0] = 1; preq[1] = 1; preq[16] = 1;
    tick();
    chk("R8 rr first", grant, 32'h1);
    finish_burst(0, "R9 gap cycle");
    tick();
    chk("R8 rr second", grant, 32'h2);
    finish_burst(1, "R9 gap cycle");
    tick();
    chk("R8 rr third", grant, 32'h0001_0000);
    finish_burst(16, "R9 gap cycle");
    tick();
    chk("R8 rr wrap", grant, 32'h1);
    preq = '0;
    finish_burst(0, "R9 gap cycle");

    // R6: channel 2 not running
    run[2] = 0;
    preq[2] = 1; preq[8] = 1;
    tick();
    chk("R6 stopped channel skipped", grant, 32'h100);
    preq = '0;
    finish_burst(8, "R9 gap cycle");
    run = '1;

    // R7 levels 1 vs 3
    preq[12] = 1; preq[4] = 1;
    tick();
    chk("R7 level 1 over level 3", grant, 32'h10);
    preq = '0;
    finish_burst(4, "R9 gap cycle");

    // R4 remove route
    wr(13'h114, 32'h0);
    preq[5] = 1;
    #1 chk("R4 cleared route", ch_req, 32'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule